// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block receives UART-style character frames from one serial input. It is clocked by the system clock and advances its bit timing on a single-cycle `tick` that arrives at sixteen times the baud rate. The input is first passed through a two-flop synchronizer. A 1-to-0 transition on the synchronized line starts a frame, but only while the receiver is enabled. The block then votes on the start bit, shifts in eight data bits LSB first, optionally shifts in a ninth bit, and finally samples the stop bit.

When the stop bit has been voted, the assembled word is copied to the output buffer and a one-clock receive interrupt is pulsed. A stop bit that votes low also pulses an error interrupt in the same cycle. In wake-up mode with nine-bit frames, any frame whose ninth bit is 0 is dropped without a trace. This lets a node on a multidrop line skip traffic until an address frame arrives. Clearing the enable never cuts a frame short: the frame in progress completes, and any later start bits are ignored.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, `rx_data` and `rx_bit9` are 0 and neither `rx_irq` nor `err_irq` is asserted.
- R2: A frame begins only on a 1-to-0 transition of the synchronized serial input while `rx_en` is 1. A line that is already low when the receiver is enabled does not start a frame.
- R3: Each bit period spans 16 ticks. The value of a bit is the majority of the 7th, 8th and 9th tick samples counted from the start of that bit period, so a disturbance that covers only one of those samples is rejected.
- R4: If the start bit votes 1, the receiver returns to idle without any buffer update or interrupt, and the next falling edge can start a new frame.
- R5: Data bits arrive least significant bit first into `rx_data[7:0]`. With `nine_bit` = 1, a ninth bit follows the data and appears on `rx_bit9`. With `nine_bit` = 0, `rx_bit9` is loaded with 0.
- R6: At the 9th sample of the stop bit, the buffer is loaded and `rx_irq` pulses for exactly one clock, whether or not the stop bit is valid.
- R7: A stop bit that votes 0 asserts `err_irq` for one clock, in the same cycle as `rx_irq`.
- R8: Clearing `rx_en` during a frame lets that frame complete with its interrupts. Start bits that arrive while `rx_en` is 0 are ignored, and the buffer keeps its value.
- R9: With `wake_mode` = 1 and `nine_bit` = 1, a frame whose ninth bit is 0 changes neither the buffer nor either interrupt. A frame whose ninth bit is 1 is delivered normally.
- R10: `rx_data` and `rx_bit9` change only in a cycle where `rx_irq` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-clock strobe at 16x the baud rate |
| rxd | input | 1 | Serial input, idles high |
| rx_en | input | 1 | Receiver enable; gates the recognition of new start bits |
| wake_mode | input | 1 | Drop nine-bit frames whose ninth bit is 0 |
| nine_bit | input | 1 | Static select for frames with a ninth bit |
| rx_data | output | 8 | Received data buffer |
| rx_bit9 | output | 1 | Received ninth bit |
| rx_irq | output | 1 | One-clock pulse when the buffer is loaded |
| err_irq | output | 1 | One-clock pulse on a stop bit that votes 0 |

## Verification
The bench builds the block with its defaults of 8 data bits and 16 samples per bit. It drives a tick on every fourth clock, so one bit lasts 64 clocks. This short period makes a few dozen complete frames affordable. It also lets a glitch of exactly one tick width land inside the three-sample voting window of every bit. Random frames mix data, the nine-bit and wake-up modes, the ninth bit and the stop-bit value. Directed frames cover false starts, a line held low during enable, and an enable drop in the middle of a frame.

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              wake_mode,
  input  logic              nine_bit,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_irq,
  output logic              err_irq
);

  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DATA_W + 3);
  localparam logic [CW-1:0] S_A   = CW'(OSR/2 - 2);
  localparam logic [CW-1:0] S_B   = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] S_V   = CW'(OSR/2);
  localparam logic [CW-1:0] S_END = CW'(OSR - 1);

  logic [2:0]      sync;
  logic            busy;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bcnt;
  logic            v_a, v_b;
  logic [DATA_W:0] shreg;

  wire            line   = sync[1];
  wire            fall   = sync[2] & ~sync[1];
  wire            vote   = (v_a & v_b) | (v_a & line) | (v_b & line);
  wire [BW-1:0]   stop_i = nine_bit ? BW'(DATA_W + 2) : BW'(DATA_W + 1);
  wire            keep   = ~(wake_mode & nine_bit & ~shreg[DATA_W]);
  wire [BW-1:0]   widx   = bcnt - BW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync    <= 3'b111;
      busy    <= 1'b0;
      cnt     <= '0;
      bcnt    <= '0;
      v_a     <= 1'b1;
      v_b     <= 1'b1;
      shreg   <= '0;
      rx_data <= '0;
      rx_bit9 <= 1'b0;
      rx_irq  <= 1'b0;
      err_irq <= 1'b0;
    end else begin
      sync    <= {sync[1:0], rxd};
      rx_irq  <= 1'b0;
      err_irq <= 1'b0;
      if (!busy) begin
        if (fall && rx_en) begin
          busy <= 1'b1;
          cnt  <= '0;
          bcnt <= '0;
        end
      end else if (tick) begin
        cnt <= (cnt == S_END) ? '0 : cnt + CW'(1);
        if (cnt == S_END) bcnt <= bcnt + BW'(1);
        if (cnt == S_A) v_a <= line;
        if (cnt == S_B) v_b <= line;
        if (cnt == S_V) begin
          if (bcnt == '0) begin
            if (vote) busy <= 1'b0;
          end else if (bcnt == stop_i) begin
            busy <= 1'b0;
            if (keep) begin
              rx_data <= shreg[DATA_W-1:0];
              rx_bit9 <= nine_bit & shreg[DATA_W];
              rx_irq  <= 1'b1;
              err_irq <= ~vote;
            end
          end else begin
            shreg[widx] <= vote;
          end
        end
      end
    end
  end

endmodule

module uart_os_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              wake_mode,
  input logic              nine_bit,
  input logic              busy,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_bit9,
  input logic              rx_irq,
  input logic              err_irq
);

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq); // R6

  AST_ERR_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> rx_irq); // R7

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_irq |-> ($stable(rx_data) && $stable(rx_bit9))); // R10

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rx_en)); // R2

  AST_WAKE_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && wake_mode && nine_bit) |-> rx_bit9); // R9

endmodule

bind uart_os_rx uart_os_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .wake_mode(wake_mode),
  .nine_bit(nine_bit), .busy(busy), .rx_data(rx_data), .rx_bit9(rx_bit9),
  .rx_irq(rx_irq), .err_irq(err_irq)
);

// File: tb/uart_os_rx_tb.sv
module uart_os_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic       rx_en = 1'b0;
  logic       wake_mode = 1'b0;
  logic       nine_bit = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_irq, err_irq;

  int errors = 0, checks = 0;
  int irq_cnt = 0, err_cnt = 0;
  logic [1:0] tdiv = 2'd0;
  logic [7:0] exp_data = 8'h00;
  logic       exp_b9 = 1'b0;

  uart_os_rx u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .rx_en(rx_en),
    .wake_mode(wake_mode), .nine_bit(nine_bit), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3);
    if (rx_irq) irq_cnt <= irq_cnt + 1;
    if (err_irq) err_cnt <= err_cnt + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic v, input bit glitch);
    rxd = v;
    wait_clk(28);
    if (glitch) begin
      rxd = ~v;
      wait_clk(4);
      rxd = v;
      wait_clk(32);
    end else wait_clk(36);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic b9,
                            input logic stop_v, input bit glitch,
                            input int drop_en_at);
    send_bit(1'b0, glitch);
    for (int i = 0; i < 8; i++) begin
      if (i == drop_en_at) rx_en = 1'b0;
      send_bit(d[i], glitch);
    end
    if (nine_bit) send_bit(b9, glitch);
    send_bit(stop_v, 1'b0);
    rxd = 1'b1;
    wait_clk(16);
  endtask

  function automatic bit delivers(input bit en, input bit w, input bit n, input bit b9);
    return en && !(w && n && !b9);
  endfunction

  task automatic frame_check(input string req, input logic [7:0] d, input logic b9,
                             input logic stop_v, input bit glitch, input int drop_at);
    int i0, e0;
    bit dl;
    i0 = irq_cnt;
    e0 = err_cnt;
    dl = delivers(rx_en, wake_mode, nine_bit, b9);
    send_frame(d, b9, stop_v, glitch, drop_at);
    if (dl) begin
      exp_data = d;
      exp_b9 = nine_bit & b9;
    end
    check({req, " irq"}, irq_cnt - i0, dl ? 1 : 0);
    check({req, " err"}, err_cnt - e0, (dl && !stop_v) ? 1 : 0);
    check({req, " data"}, int'(rx_data), int'(exp_data));
    check({req, " bit9"}, int'(rx_bit9), int'(exp_b9));
  endtask

  initial begin
    int i0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    check("R1 data", int'(rx_data), 0);
    check("R1 bit9", int'(rx_bit9), 0);
    check("R1 irq", int'(rx_irq) + int'(err_irq), 0);

    rx_en = 1'b1;
    frame_check("R5 R6 basic", 8'hA5, 1'b0, 1'b1, 1'b0, -1);
    frame_check("R3 glitched", 8'h3C, 1'b0, 1'b1, 1'b1, -1);

    i0 = irq_cnt;
    rxd = 1'b0; wait_clk(8); rxd = 1'b1; wait_clk(200);
    check("R4 false start irq", irq_cnt - i0, 0);
    check("R4 false start data", int'(rx_data), int'(exp_data));
    frame_check("R4 after false start", 8'h5A, 1'b0, 1'b1, 1'b0, -1);

    rx_en = 1'b0; rxd = 1'b0; wait_clk(20);
    rx_en = 1'b1; i0 = irq_cnt; wait_clk(1000); rxd = 1'b1; wait_clk(20);
    check("R2 low line no start", irq_cnt - i0, 0);

    frame_check("R7 framing error", 8'hC3, 1'b0, 1'b0, 1'b0, -1);

    nine_bit = 1'b1;
    frame_check("R5 ninth bit", 8'h81, 1'b1, 1'b1, 1'b0, -1);
    frame_check("R5 ninth bit zero", 8'h7E, 1'b0, 1'b1, 1'b0, -1);
    wake_mode = 1'b1;
    frame_check("R9 wake drop", 8'h12, 1'b0, 1'b0, 1'b0, -1);
    frame_check("R9 wake pass", 8'h34, 1'b1, 1'b1, 1'b0, -1);
    wake_mode = 1'b0;
    nine_bit = 1'b0;

    i0 = irq_cnt;
    send_frame(8'h96, 1'b0, 1'b1, 1'b0, 3);
    exp_data = 8'h96; exp_b9 = 1'b0;
    check("R8 drop mid frame irq", irq_cnt - i0, 1);
    check("R8 drop mid frame data", int'(rx_data), 8'h96);
    frame_check("R8 disabled ignored", 8'h69, 1'b0, 1'b1, 1'b0, -1);
    rx_en = 1'b1;

    void'($urandom(32'd1234));
    for (int k = 0; k < 30; k++) begin
      logic [7:0] d;
      logic b9, sv;
      bit gl;
      d = 8'($urandom);
      b9 = 1'($urandom);
      sv = ($urandom % 5) != 0;
      gl = ($urandom % 3) == 0;
      nine_bit = 1'($urandom);
      wake_mode = 1'($urandom);
      wait_clk(1 + $urandom % 40);
      frame_check("R3 R5 R6 R7 R9 R10 random", d, b9, sv, gl, -1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule